// File: doc/BRIEF.md
# Receive Interrupt Moderation Timers

This block decides when a network receiver raises its receive interrupt. Two countdown timers run on a shared microsecond tick. The first is an inter-packet delay timer. It restarts each time a packet finishes landing in host memory, so it fires once traffic has been quiet for a programmed interval. The second is an absolute timer. It starts on the first completed packet and is never pushed back, so it caps the latency that the first packet of a burst can see.

Whichever timer runs out first produces one interrupt pulse. Any receive interrupt, including one raised elsewhere for a small packet, puts both timers back into their idle state. They stay idle until the next completed packet arrives.

Software programs each interval through a 32-bit write word whose low bits hold the count. Setting the top bit of either write also asks the descriptor engine to write back any partially used descriptor cache lines and publish the head pointer. That request leaves the block as a one-cycle flush pulse.

Top module: `rxim_top`

## Requirements
- R1: A completed packet loads the delay timer with the stored delay value, whether or not the timer is already running. After that load, the Nth following tick raises `irq_pulse` on the next clock cycle, provided no further packet completes before that tick.
- R2: While the stored delay value is 0, both timers stay inactive and every completed packet raises `irq_pulse` on the next cycle. No tick ever raises an interrupt in this state.
- R3: The absolute timer loads the stored absolute value only on a completed packet that finds it inactive. Later packets do not reload it, so it expires on the Mth tick counted from that first packet.
- R4: An expiry of either timer leaves both timers inactive. No further interrupt occurs, however many ticks arrive, until another packet completes.
- R5: A `small_pkt_evt` pulse makes both timers inactive without raising `irq_pulse`. The next completed packet starts them afresh.
- R6: If a timer expires in the same cycle that a packet completes, `irq_pulse` is still raised. Both timers then restart from that packet with full intervals.
- R7: A stored absolute value of 0 disables only the absolute timer. The delay timer keeps working as in R1.
- R8: A write with bit 31 set, on either write port, raises `flush_req` for exactly one cycle, starting on the cycle after the write. Only bits 15:0 are stored as the interval, so bit 31 never becomes part of a count.
- R9: A newly written interval takes effect at the next load. A count already in progress keeps its original length.
- R10: `irq_pulse` lasts a single cycle per interrupt event. When both timers expire on the same tick, only one pulse is produced.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_us | input | 1 | One-cycle microsecond tick that decrements running timers |
| pkt_done | input | 1 | One-cycle strobe: a packet has been completely written to host memory |
| small_pkt_evt | input | 1 | One-cycle strobe: a small-packet interrupt was raised elsewhere |
| dly_wr_en | input | 1 | Write strobe for the delay interval word |
| dly_wr_data | input | 32 | Delay interval in bits 15:0; bit 31 requests a flush |
| abs_wr_en | input | 1 | Write strobe for the absolute interval word |
| abs_wr_data | input | 32 | Absolute interval in bits 15:0; bit 31 requests a flush |
| irq_pulse | output | 1 | One-cycle receive interrupt pulse |
| flush_req | output | 1 | One-cycle descriptor write-back request |

## Verification
The situations hardest to reach from the ports are coincidences of events on the same cycle. One is both timers reaching zero on the same tick. Another is an expiry landing on the exact cycle that a packet completes. A third is an interval rewrite arriving while a count is half done.

Because the tick is an input, the bench steps time one tick at a time and places each packet after a precise number of ticks. The vector table is sized so that the absolute and delay deadlines meet on one tick. Directed tests drive the tick and the packet strobe together on the cycle of the final tick.

// File: rtl/rxim_pkg.sv
package rxim_pkg;
   parameter int RXIM_CNT_W  = 16;
   parameter int RXIM_WORD_W = 32;
   parameter int RXIM_N_TMR  = 2;

   typedef enum logic [0:0] {
      TMR_GAP = 1'b0,
      TMR_ABS = 1'b1
   } rxim_tmr_e;
endpackage

// File: rtl/rxim_cfg.sv
module rxim_cfg #(
   parameter int WORD_W    = 32,
   parameter int CNT_W     = 16,
   parameter int FLUSH_BIT = WORD_W - 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              gap_wr_en,
   input  logic [WORD_W-1:0] gap_wr_data,
   input  logic              abs_wr_en,
   input  logic [WORD_W-1:0] abs_wr_data,
   output logic [CNT_W-1:0]  gap_ival,
   output logic [CNT_W-1:0]  abs_ival,
   output logic              flush_pulse
);
   logic [CNT_W-1:0] gap_q, abs_q;
   logic             flush_q;
   logic             flush_hit;

   assign flush_hit = (gap_wr_en & gap_wr_data[FLUSH_BIT])
                    | (abs_wr_en & abs_wr_data[FLUSH_BIT]);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         gap_q   <= '0;
         abs_q   <= '0;
         flush_q <= 1'b0;
      end else begin
         if (gap_wr_en) gap_q <= gap_wr_data[CNT_W-1:0];
         if (abs_wr_en) abs_q <= abs_wr_data[CNT_W-1:0];
         flush_q <= flush_hit;
      end
   end

   assign gap_ival    = gap_q;
   assign abs_ival    = abs_q;
   assign flush_pulse = flush_q;
endmodule

// File: rtl/rxim_countdown.sv
module rxim_countdown #(
   parameter int CNT_W       = 16,
   parameter bit RELOAD_EACH = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             en,
   input  logic             tick,
   input  logic             evt,
   input  logic             clr,
   input  logic [CNT_W-1:0] load_val,
   output logic             active,
   output logic [CNT_W-1:0] count,
   output logic             expire
);
   localparam logic [CNT_W-1:0] LAST = CNT_W'(1);

   logic             act_q;
   logic [CNT_W-1:0] cnt_q;
   logic             load_go;

   generate
      if (RELOAD_EACH) begin : g_restartable
         assign load_go = evt;
      end else begin : g_oneshot
         assign load_go = evt & (~act_q | clr);
      end
   endgenerate

   assign expire = act_q & en & tick & (cnt_q == LAST);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         act_q <= 1'b0;
         cnt_q <= '0;
      end else if (!en) begin
         act_q <= 1'b0;
      end else if (load_go) begin
         act_q <= 1'b1;
         cnt_q <= load_val;
      end else if (clr | expire) begin
         act_q <= 1'b0;
      end else if (act_q & tick) begin
         cnt_q <= cnt_q - LAST;
      end
   end

   assign active = act_q;
   assign count  = cnt_q;
endmodule

// File: rtl/rxim_top.sv
module rxim_top
   import rxim_pkg::*;
#(
   parameter int CNT_W  = RXIM_CNT_W,
   parameter int WORD_W = RXIM_WORD_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tick_us,
   input  logic              pkt_done,
   input  logic              small_pkt_evt,
   input  logic              dly_wr_en,
   input  logic [WORD_W-1:0] dly_wr_data,
   input  logic              abs_wr_en,
   input  logic [WORD_W-1:0] abs_wr_data,
   output logic              irq_pulse,
   output logic              flush_req
);
   localparam int FLUSH_BIT = WORD_W - 1;

   generate
      if (CNT_W < 1 || CNT_W >= WORD_W) begin : g_bad_width
         $error("rxim_top: CNT_W must be at least 1 and below WORD_W");
      end
   endgenerate

   logic [CNT_W-1:0] cfg_dly, cfg_abs;
   logic             dly_en, abs_en;
   logic             clr_all;
   logic             irq_q;

   logic [RXIM_N_TMR-1:0] tmr_en, tmr_act, tmr_exp;
   logic [CNT_W-1:0]      tmr_load [RXIM_N_TMR];
   logic [CNT_W-1:0]      tmr_cnt  [RXIM_N_TMR];

   rxim_cfg #(
      .WORD_W(WORD_W), .CNT_W(CNT_W), .FLUSH_BIT(FLUSH_BIT)
   ) u_cfg (
      .clk(clk), .rst_n(rst_n),
      .gap_wr_en(dly_wr_en), .gap_wr_data(dly_wr_data),
      .abs_wr_en(abs_wr_en), .abs_wr_data(abs_wr_data),
      .gap_ival(cfg_dly), .abs_ival(cfg_abs),
      .flush_pulse(flush_req)
   );

   assign dly_en  = (cfg_dly != '0);
   assign abs_en  = dly_en & (cfg_abs != '0);
   assign clr_all = small_pkt_evt | (|tmr_exp);

   assign tmr_en[TMR_GAP]   = dly_en;
   assign tmr_en[TMR_ABS]   = abs_en;
   assign tmr_load[TMR_GAP] = cfg_dly;
   assign tmr_load[TMR_ABS] = cfg_abs;

   generate
      for (genvar i = 0; i < RXIM_N_TMR; i++) begin : g_tmr
         rxim_countdown #(
            .CNT_W(CNT_W),
            .RELOAD_EACH(i == int'(TMR_GAP))
         ) u_cd (
            .clk(clk), .rst_n(rst_n),
            .en(tmr_en[i]), .tick(tick_us),
            .evt(pkt_done), .clr(clr_all),
            .load_val(tmr_load[i]),
            .active(tmr_act[i]), .count(tmr_cnt[i]),
            .expire(tmr_exp[i])
         );
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n) irq_q <= 1'b0;
      else        irq_q <= (|tmr_exp) | (pkt_done & ~dly_en);
   end

   assign irq_pulse = irq_q;
endmodule

// File: rtl/rxim_checker.sv
module rxim_checker #(
   parameter int CNT_W  = 16,
   parameter int WORD_W = 32
) (
   input logic              clk,
   input logic              rst_n,
   input logic              tick_us,
   input logic              pkt_done,
   input logic              small_pkt_evt,
   input logic              dly_wr_en,
   input logic [WORD_W-1:0] dly_wr_data,
   input logic              abs_wr_en,
   input logic [WORD_W-1:0] abs_wr_data,
   input logic              irq_pulse,
   input logic              flush_req,
   input logic [CNT_W-1:0]  cfg_dly,
   input logic              gap_act,
   input logic              abs_act,
   input logic [CNT_W-1:0]  gap_cnt,
   input logic [CNT_W-1:0]  abs_cnt
);
   p_gap_load_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (pkt_done && cfg_dly != '0) |=> (gap_act && gap_cnt == $past(cfg_dly)));

   p_zero_immediate_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (pkt_done && cfg_dly == '0) |=> irq_pulse);

   p_zero_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_dly == '0) |=> (!gap_act && !abs_act));

   p_abs_no_reload_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (abs_act && pkt_done && !tick_us && !small_pkt_evt) |=> $stable(abs_cnt));

   p_small_clears_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (small_pkt_evt && !pkt_done) |=> (!gap_act && !abs_act));

   p_flush_gap_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (dly_wr_en && dly_wr_data[WORD_W-1]) |=> flush_req);

   p_flush_abs_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (abs_wr_en && abs_wr_data[WORD_W-1]) |=> flush_req);
endmodule

bind rxim_top rxim_checker #(.CNT_W(CNT_W), .WORD_W(WORD_W)) u_rxim_chk (
   .clk(clk), .rst_n(rst_n), .tick_us(tick_us), .pkt_done(pkt_done),
   .small_pkt_evt(small_pkt_evt), .dly_wr_en(dly_wr_en),
   .dly_wr_data(dly_wr_data), .abs_wr_en(abs_wr_en),
   .abs_wr_data(abs_wr_data), .irq_pulse(irq_pulse),
   .flush_req(flush_req), .cfg_dly(cfg_dly),
   .gap_act(tmr_act[0]), .abs_act(tmr_act[1]),
   .gap_cnt(tmr_cnt[0]), .abs_cnt(tmr_cnt[1])
);

// File: tb/tb_rxim_top.sv
module tb_rxim_top;
   localparam int CLK_PERIOD = 10;
   localparam int N_VEC = 7;
   localparam int WATCHDOG = 150000;

   // vector table: delay, absolute, packets, ticks between packets
   localparam int T_DLY [N_VEC] = '{5, 5, 4, 6, 3, 7, 2};
   localparam int T_ABS [N_VEC] = '{0, 0, 10, 8, 20, 0, 5};
   localparam int T_NPK [N_VEC] = '{1, 3, 3, 4, 2, 4, 1};
   localparam int T_GAP [N_VEC] = '{0, 2, 3, 2, 1, 5, 0};

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        tick_us = 1'b0;
   logic        pkt_done = 1'b0;
   logic        small_pkt_evt = 1'b0;
   logic        dly_wr_en = 1'b0;
   logic [31:0] dly_wr_data = '0;
   logic        abs_wr_en = 1'b0;
   logic [31:0] abs_wr_data = '0;
   logic        irq_pulse;
   logic        flush_req;

   int n_chk = 0;
   int n_fail = 0;
   int cyc = 0;

   rxim_top dut (
      .clk(clk), .rst_n(rst_n), .tick_us(tick_us), .pkt_done(pkt_done),
      .small_pkt_evt(small_pkt_evt), .dly_wr_en(dly_wr_en),
      .dly_wr_data(dly_wr_data), .abs_wr_en(abs_wr_en),
      .abs_wr_data(abs_wr_data), .irq_pulse(irq_pulse),
      .flush_req(flush_req)
   );

   always #(CLK_PERIOD/2) clk = ~clk;

   always @(posedge clk) begin
      cyc <= cyc + 1;
      if (cyc > WATCHDOG) begin
         n_fail = n_fail + 1;
         $display("FAIL watchdog: run hung, actual cycles %0d expected below %0d", cyc, WATCHDOG);
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end

   task automatic check(input bit ok, input string req, input int act, input int exp);
      n_chk = n_chk + 1;
      if (!ok) begin
         n_fail = n_fail + 1;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic do_tick(output logic seen);
      @(negedge clk) tick_us = 1'b1;
      @(negedge clk) tick_us = 1'b0;
      seen = irq_pulse;
   endtask

   task automatic do_pkt(output logic seen);
      @(negedge clk) pkt_done = 1'b1;
      @(negedge clk) pkt_done = 1'b0;
      seen = irq_pulse;
   endtask

   task automatic do_both(output logic seen);
      @(negedge clk) begin tick_us = 1'b1; pkt_done = 1'b1; end
      @(negedge clk) begin tick_us = 1'b0; pkt_done = 1'b0; end
      seen = irq_pulse;
   endtask

   task automatic do_small();
      @(negedge clk) small_pkt_evt = 1'b1;
      @(negedge clk) small_pkt_evt = 1'b0;
   endtask

   task automatic wr_dly(input logic [31:0] d, output logic fl);
      @(negedge clk) begin dly_wr_en = 1'b1; dly_wr_data = d; end
      @(negedge clk) dly_wr_en = 1'b0;
      fl = flush_req;
   endtask

   task automatic wr_abs(input logic [31:0] d, output logic fl);
      @(negedge clk) begin abs_wr_en = 1'b1; abs_wr_data = d; end
      @(negedge clk) abs_wr_en = 1'b0;
      fl = flush_req;
   endtask

   // ticks until an interrupt, 0 if none within the limit
   task automatic ticks_to_irq(input int limit, output int k);
      logic s;
      k = 0;
      for (int t = 1; t <= limit; t++) begin
         do_tick(s);
         if (s && k == 0) begin
            k = t;
            break;
         end
      end
   endtask

   task automatic quiet(input int n, output int hits);
      logic s;
      hits = 0;
      for (int t = 0; t < n; t++) begin
         do_tick(s);
         if (s) hits++;
      end
   endtask

   function automatic int expect_ticks(input int d, input int a, input int n, input int g);
      int dl;
      dl = d + (n - 1) * g;
      if (a != 0 && a < dl) return a;
      return dl;
   endfunction

   initial begin
      logic s, fl;
      int k, hits, meas, ex, early;

      repeat (3) @(negedge clk);
      check(irq_pulse == 1'b0 && flush_req == 1'b0, "R4 reset outputs idle",
            int'({irq_pulse, flush_req}), 0);
      @(negedge clk) rst_n = 1'b1;

      // vector walk: R1 R3 R4 R7 R10
      for (int i = 0; i < N_VEC; i++) begin
         wr_dly(32'(T_DLY[i]), fl);
         wr_abs(32'(T_ABS[i]), fl);
         early = 0;
         for (int p = 0; p < T_NPK[i]; p++) begin
            do_pkt(s);
            if (s) early++;
            if (p < T_NPK[i] - 1) begin
               for (int g = 0; g < T_GAP[i]; g++) begin
                  do_tick(s);
                  if (s) early++;
               end
            end
         end
         ticks_to_irq(100, k);
         meas = (T_NPK[i] - 1) * T_GAP[i] + k;
         ex = expect_ticks(T_DLY[i], T_ABS[i], T_NPK[i], T_GAP[i]);
         check(early == 0 && k != 0 && meas == ex,
               $sformatf("R1 R3 R7 vector %0d ticks to irq", i), meas, ex);
         quiet(12, hits);
         check(hits == 0, $sformatf("R4 R10 vector %0d no irq after expiry", i), hits, 0);
      end

      // R2: zero delay -> immediate, abs timer disabled too
      wr_dly(32'd0, fl);
      wr_abs(32'd3, fl);
      do_pkt(s);
      check(s == 1'b1, "R2 immediate irq on packet", int'(s), 1);
      quiet(8, hits);
      check(hits == 0, "R2 no timed irq with zero delay", hits, 0);
      do_pkt(s);
      check(s == 1'b1, "R2 second packet immediate irq", int'(s), 1);

      // R5: small packet clears both timers
      wr_dly(32'd5, fl);
      wr_abs(32'd8, fl);
      do_pkt(s);
      quiet(2, hits);
      do_small();
      @(negedge clk);
      check(irq_pulse == 1'b0, "R5 small event raises no irq", int'(irq_pulse), 0);
      quiet(15, hits);
      check(hits == 0, "R5 timers idle after small event", hits, 0);
      do_pkt(s);
      ticks_to_irq(30, k);
      check(k == 5, "R5 fresh start after small event", k, 5);

      // R6: expiry coincides with packet
      wr_dly(32'd3, fl);
      wr_abs(32'd0, fl);
      do_pkt(s);
      quiet(2, hits);
      do_both(s);
      check(s == 1'b1 && hits == 0, "R6 irq on expiry with packet", int'(s), 1);
      ticks_to_irq(30, k);
      check(k == 3, "R6 restart from coincident packet", k, 3);

      // R8: flush bit
      wr_dly(32'h8000_0004, fl);
      check(fl == 1'b1, "R8 flush from delay write", int'(fl), 1);
      @(negedge clk);
      check(flush_req == 1'b0, "R8 flush lasts one cycle", int'(flush_req), 0);
      wr_abs(32'h8000_0000, fl);
      check(fl == 1'b1, "R8 flush from absolute write", int'(fl), 1);
      wr_abs(32'h0000_0009, fl);
      check(fl == 1'b0, "R8 no flush without bit 31", int'(fl), 0);
      do_pkt(s);
      ticks_to_irq(30, k);
      check(k == 4, "R8 bit 31 not part of count", k, 4);

      // R9: rewrite mid-count affects next load only
      wr_dly(32'd10, fl);
      wr_abs(32'd0, fl);
      do_pkt(s);
      quiet(2, hits);
      wr_dly(32'd3, fl);
      ticks_to_irq(30, k);
      check(k == 8, "R9 running count keeps old interval", k + 2, 10);
      do_pkt(s);
      ticks_to_irq(30, k);
      check(k == 3, "R9 new interval on next load", k, 3);

      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end
endmodule